// File: doc/BRIEF.md
# Multichannel TDM Serial Transmitter

This block sends data words into a time-division frame of up to 128 word slots, one bit per bit-clock cycle, most significant bit first. A frame starts when the frame sync pulse is sampled. From then on the block steps through the slots until it reaches the programmed frame length, and then it goes idle until the next frame sync arrives.

At the start of each slot, a 2-bit selection mode and three per-slot bit vectors place the slot in one of three states. An enabled and unmasked slot copies the holding register into the shift path and drives the line. An enabled but masked slot still makes the copy and raises the ready event, but it keeps the line released, so its word is never completed on the wire. A disabled slot makes no copy, raises no event and leaves the empty flag as it is.

Software-side logic writes words into the holding register. It uses the ready flag, or the one-cycle request pulse, to pace those writes. A partition control folds the slot selection vectors onto their lowest 32 bits.

Top module: `tdm_slot_tx`

## Requirements
- R1: With mode code 00, every slot in the frame copies a word and drives the line.
- R2: With mode code 01, a slot is enabled only when its bit in `txEnable` is set. Only enabled slots drive the line. For example, in a 40-slot frame with bits 0, 15 and 39 set, only those three slots are driven.
- R3: With mode code 10, every slot copies a word, but a slot drives the line only when its bit in `txMask` is set.
- R4: With mode code 11, the bits of `rxEnable` decide which slots are enabled. An enabled slot drives the line only when its bit in `txMask` is also set.
- R5: Each enabled slot copies the holding register at the start of the slot, whether it is masked or not. The copy sets `txReady` and gives a one-cycle `txRequest` pulse in the first bit time of that slot.
- R6: A disabled slot makes no copy and gives no `txRequest` pulse. `txReady` is left unchanged.
- R7: A disabled slot leaves `txEmpty` unchanged. A copy sets `txEmpty` to 1 when the holding register had not been rewritten since the previous copy, and to 0 when it had.
- R8: `frameLen` holds the slot count minus one. Word length code c gives 8+4c bits for c up to 6; code 7 also gives 32 bits. After the last bit of slot `frameLen`, the block stops and `serialOe` goes low.
- R9: Bit 0 of slot 0 is presented in the cycle after the edge that samples `frameSync`. Each later bit follows one cycle after the previous one, and the word goes out MSB first from the low word-length bits of the copied value.
- R10: When `allPartitions` is 0, slot s uses selection bit s mod 32 in every vector. When it is 1, slot s uses bit s.
- R11: Reset gives `txReady`=1, `txEmpty`=1, `serialOe`=0 and `txRequest`=0. A write to the holding register clears `txReady` at the next edge, even when a copy happens at that same edge.
- R12: `serialOut` is 0 whenever `serialOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Frame start pulse |
| modeSel | input | 2 | Slot selection mode code |
| allPartitions | input | 1 | 1: all 128 selection bits used; 0: bits folded mod 32 |
| frameLen | input | 7 | Slot count minus one |
| wordLenCode | input | 3 | Word length code |
| txEnable | input | 128 | Per-slot transmit enable bits |
| txMask | input | 128 | Per-slot drive (unmask) bits |
| rxEnable | input | 128 | Per-slot receive enable bits, used in mode 11 |
| dataIn | input | 32 | Word for the holding register, right-aligned |
| dataWrite | input | 1 | Holding register write strobe |
| serialOut | output | 1 | Serial data |
| serialOe | output | 1 | Line drive enable; 0 means released |
| txReady | output | 1 | Holding register may be rewritten |
| txRequest | output | 1 | One-cycle pulse on each copy |
| txEmpty | output | 1 | Last copy found no new word |

## Verification
The serial line is due one cycle after each sampling edge. Bit b of slot s appears in the cycle after the frame sync edge plus s times the word length plus b cycles. `txRequest` and the flag updates appear in the first bit time of the slot. The release of the line at the end of a frame is due in the cycle after the last bit. The driver pushes the expected (drive, data) pair for every bit time right after the frame sync edge, and the monitor pops one pair at each falling edge, so the comparisons stay locked to that schedule. Request pulses are counted on the same falling edges. The flags and the idle state are read one cycle after the frame's queue drains, once all updates have settled.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  typedef enum logic [1:0] {
    SEL_ALL       = 2'b00,
    SEL_ENABLED   = 2'b01,
    SEL_MASKED    = 2'b10,
    SEL_SYMMETRIC = 2'b11
  } selMode_e;

  // Strobes from the slot sequencer to the datapath
  typedef struct packed {
    logic slotStart;  // a new slot begins at this edge
    logic loadWord;   // copy holding register into the shift path
    logic driveSlot;  // the new slot drives the line
    logic shiftBit;   // advance one bit inside the slot
    logic frameDone;  // last bit of the last slot ends here
  } txStrobe_t;

endpackage

// File: rtl/tdm_chan_decode.sv
module tdm_chan_decode
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS  = 128,
  parameter int PART_SLOTS = 32
) (
  input  logic [1:0]           modeSel,
  input  logic                 allPartitions,
  input  logic [NUM_SLOTS-1:0] txEnable,
  input  logic [NUM_SLOTS-1:0] txMask,
  input  logic [NUM_SLOTS-1:0] rxEnable,
  output logic [NUM_SLOTS-1:0] slotEn,
  output logic [NUM_SLOTS-1:0] slotDrv
);

  selMode_e mode;
  assign mode = selMode_e'(modeSel);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    localparam int FOLD = g % PART_SLOTS;
    logic enBit, maskBit, rxBit;
    logic en, drv;

    assign enBit   = allPartitions ? txEnable[g] : txEnable[FOLD];
    assign maskBit = allPartitions ? txMask[g]   : txMask[FOLD];
    assign rxBit   = allPartitions ? rxEnable[g] : rxEnable[FOLD];

    always_comb begin
      unique case (mode)
        SEL_ALL:       begin en = 1'b1;  drv = 1'b1;           end
        SEL_ENABLED:   begin en = enBit; drv = enBit;          end
        SEL_MASKED:    begin en = 1'b1;  drv = maskBit;        end
        SEL_SYMMETRIC: begin en = rxBit; drv = rxBit & maskBit; end
        default:       begin en = 1'b0;  drv = 1'b0;           end
      endcase
    end

    assign slotEn[g]  = en;
    assign slotDrv[g] = drv;
  end

endmodule

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 128,
  parameter int DATA_W    = 32,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int CNT_W     = $clog2(DATA_W + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameSync,
  input  logic [SLOT_W-1:0]    frameLen,
  input  logic [2:0]           wordLenCode,
  input  logic [NUM_SLOTS-1:0] slotEn,
  input  logic [NUM_SLOTS-1:0] slotDrv,
  output logic [CNT_W-1:0]     wordBits,
  output txStrobe_t            strb
);

  logic              active;
  logic [SLOT_W-1:0] slotIdx;
  logic [SLOT_W-1:0] nextSlot;
  logic [CNT_W-1:0]  bitIdx;
  logic [CNT_W:0]    rawBits;
  logic              lastBit;
  logic              lastSlot;

  assign rawBits  = (CNT_W+1)'(8) + (CNT_W+1)'({wordLenCode, 2'b00});
  assign wordBits = (rawBits > (CNT_W+1)'(DATA_W)) ? CNT_W'(DATA_W) : CNT_W'(rawBits);

  assign lastBit  = (bitIdx == wordBits - 1'b1);
  assign lastSlot = (slotIdx == frameLen);
  assign nextSlot = frameSync ? '0 : slotIdx + 1'b1;

  always_comb begin
    strb.slotStart = frameSync | (active & lastBit & ~lastSlot);
    strb.loadWord  = strb.slotStart & slotEn[nextSlot];
    strb.driveSlot = strb.slotStart & slotDrv[nextSlot];
    strb.shiftBit  = active & ~lastBit & ~frameSync;
    strb.frameDone = active & lastBit & lastSlot & ~frameSync;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      slotIdx <= '0;
      bitIdx  <= '0;
    end else if (frameSync) begin
      active  <= 1'b1;
      slotIdx <= '0;
      bitIdx  <= '0;
    end else if (active) begin
      if (lastBit) begin
        bitIdx <= '0;
        if (lastSlot) active  <= 1'b0;
        else          slotIdx <= slotIdx + 1'b1;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdm_tx_datapath.sv
module tdm_tx_datapath
  import tdm_tx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [CNT_W-1:0]  wordBits,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataWrite,
  output logic              serialOut,
  output logic              serialOe,
  output logic              txReady,
  output logic              txRequest,
  output logic              txEmpty
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  alignAmt;
  logic              oeReg;

  assign alignAmt = CNT_W'(DATA_W) - wordBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg   <= '0;
      shiftReg  <= '0;
      oeReg     <= 1'b0;
      txReady   <= 1'b1;
      txEmpty   <= 1'b1;
      txRequest <= 1'b0;
    end else begin
      txRequest <= strb.loadWord;

      if (dataWrite) holdReg <= dataIn;

      if (strb.loadWord) begin
        shiftReg <= holdReg << alignAmt;
        txEmpty  <= txReady;
      end else if (strb.shiftBit) begin
        shiftReg <= shiftReg << 1;
      end

      if (dataWrite)          txReady <= 1'b0;
      else if (strb.loadWord) txReady <= 1'b1;

      if (strb.slotStart)      oeReg <= strb.driveSlot;
      else if (strb.frameDone) oeReg <= 1'b0;
    end
  end

  assign serialOe  = oeReg;
  assign serialOut = oeReg & shiftReg[DATA_W-1];

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS  = 128,
  parameter int PART_SLOTS = 32,
  parameter int DATA_W     = 32,
  parameter int SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameSync,
  input  logic [1:0]           modeSel,
  input  logic                 allPartitions,
  input  logic [SLOT_W-1:0]    frameLen,
  input  logic [2:0]           wordLenCode,
  input  logic [NUM_SLOTS-1:0] txEnable,
  input  logic [NUM_SLOTS-1:0] txMask,
  input  logic [NUM_SLOTS-1:0] rxEnable,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic                 dataWrite,
  output logic                 serialOut,
  output logic                 serialOe,
  output logic                 txReady,
  output logic                 txRequest,
  output logic                 txEmpty
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [NUM_SLOTS-1:0] slotEn;
  logic [NUM_SLOTS-1:0] slotDrv;
  logic [CNT_W-1:0]     wordBits;
  txStrobe_t            strb;

  tdm_chan_decode #(.NUM_SLOTS(NUM_SLOTS), .PART_SLOTS(PART_SLOTS)) u_decode (
    .modeSel(modeSel), .allPartitions(allPartitions),
    .txEnable(txEnable), .txMask(txMask), .rxEnable(rxEnable),
    .slotEn(slotEn), .slotDrv(slotDrv)
  );

  tdm_tx_ctrl #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .frameLen(frameLen),
    .wordLenCode(wordLenCode), .slotEn(slotEn), .slotDrv(slotDrv),
    .wordBits(wordBits), .strb(strb)
  );

  tdm_tx_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordBits(wordBits),
    .dataIn(dataIn), .dataWrite(dataWrite),
    .serialOut(serialOut), .serialOe(serialOe),
    .txReady(txReady), .txRequest(txRequest), .txEmpty(txEmpty)
  );

endmodule

// File: rtl/tdm_slot_tx_checker.sv
module tdm_slot_tx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       frameSync,
  input logic [1:0] modeSel,
  input logic       dataWrite,
  input logic       serialOut,
  input logic       serialOe,
  input logic       txReady,
  input logic       txRequest,
  input logic       txEmpty
);

  assert_mode_all_drives_R1: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && modeSel == 2'b00) |=> serialOe);

  assert_copy_sets_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txRequest && !$past(dataWrite)) |-> txReady);

  assert_empty_moves_on_copy_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txEmpty) |-> txRequest);

  assert_write_clears_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |=> !txReady);

  assert_line_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !serialOe |-> !serialOut);

endmodule

bind tdm_slot_tx tdm_slot_tx_checker u_checker (
  .clk(clk), .rstN(rstN), .frameSync(frameSync), .modeSel(modeSel),
  .dataWrite(dataWrite), .serialOut(serialOut), .serialOe(serialOe),
  .txReady(txReady), .txRequest(txRequest), .txEmpty(txEmpty)
);

// File: tb/tdm_slot_tx_bench.sv
`timescale 1ns/1ps
module tdm_slot_tx_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         frameSync = 1'b0;
  logic [1:0]   modeSel = 2'b00;
  logic         allPartitions = 1'b1;
  logic [6:0]   frameLen = '0;
  logic [2:0]   wordLenCode = '0;
  logic [127:0] txEnable = '0;
  logic [127:0] txMask = '0;
  logic [127:0] rxEnable = '0;
  logic [31:0]  dataIn = '0;
  logic         dataWrite = 1'b0;
  logic         serialOut, serialOe, txReady, txRequest, txEmpty;

  int           nRun = 0;
  int           nFail = 0;
  int           reqCount = 0;
  bit           done = 1'b0;
  string        curTag = "";
  logic [1:0]   expQ[$];

  always #2 clk = ~clk;

  tdm_slot_tx u_tdm_slot_tx (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .modeSel(modeSel),
    .allPartitions(allPartitions), .frameLen(frameLen), .wordLenCode(wordLenCode),
    .txEnable(txEnable), .txMask(txMask), .rxEnable(rxEnable),
    .dataIn(dataIn), .dataWrite(dataWrite),
    .serialOut(serialOut), .serialOe(serialOe),
    .txReady(txReady), .txRequest(txRequest), .txEmpty(txEmpty)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Monitor: one expected (drive, data) pair per bit time
  always @(negedge clk) begin
    if (rstN && txRequest) reqCount++;
    if (expQ.size() > 0) begin
      logic [1:0] item;
      item = expQ.pop_front();
      check({serialOe, serialOut} == item, curTag, "line {oe,data}",
            {serialOe, serialOut}, item);
    end
  end

  function automatic void chanBits(input logic [1:0] m, input bit allP, input int s,
                                   input logic [127:0] en, input logic [127:0] mk,
                                   input logic [127:0] rx, output bit e, output bit d);
    int k;
    k = allP ? s : s % 32;
    case (m)
      2'b00:   begin e = 1'b1;  d = 1'b1;          end
      2'b01:   begin e = en[k]; d = en[k];         end
      2'b10:   begin e = 1'b1;  d = mk[k];         end
      default: begin e = rx[k]; d = rx[k] & mk[k]; end
    endcase
  endfunction

  task automatic runFrame(input string tag, input logic [1:0] m, input bit allP,
                          input int nWords, input int code, input logic [127:0] en,
                          input logic [127:0] mk, input logic [127:0] rx,
                          input logic [31:0] word);
    int  wBits;
    int  nEn;
    bit  prevEmpty;
    wBits = (code >= 6) ? 32 : 8 + 4 * code;
    modeSel = m; allPartitions = allP; frameLen = 7'(nWords - 1);
    wordLenCode = 3'(code); txEnable = en; txMask = mk; rxEnable = rx;
    dataIn = word; dataWrite = 1'b1;
    step();
    dataWrite = 1'b0;
    check(txReady == 1'b0, "R11", "ready after write", txReady, 0);
    prevEmpty = txEmpty;
    frameSync = 1'b1;
    step();
    frameSync = 1'b0;
    curTag = tag;
    reqCount = 0;
    nEn = 0;
    for (int s = 0; s < nWords; s++) begin
      bit e, d;
      chanBits(m, allP, s, en, mk, rx, e, d);
      if (e) nEn++;
      for (int b = 0; b < wBits; b++)
        expQ.push_back({d, d & word[wBits-1-b]});
    end
    while (expQ.size() != 0) @(posedge clk);
    step();
    check(serialOe == 1'b0, "R8", "line released after frame", serialOe, 0);
    check(reqCount == nEn, nEn > 0 ? "R5" : "R6", "request count", reqCount, nEn);
    check(txReady == (nEn > 0), nEn > 0 ? "R5" : "R6", "ready after frame",
          txReady, (nEn > 0));
    check(txEmpty == ((nEn == 0) ? prevEmpty : (nEn > 1)), "R7", "empty after frame",
          txEmpty, (nEn == 0) ? prevEmpty : (nEn > 1));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [127:0] en, mk, rx;
    repeat (3) step();
    check(serialOe == 1'b0, "R11", "reset oe", serialOe, 0);
    check(txReady == 1'b1, "R11", "reset ready", txReady, 1);
    check(txEmpty == 1'b1, "R11", "reset empty", txEmpty, 1);
    check(txRequest == 1'b0, "R11", "reset request", txRequest, 0);
    rstN = 1'b1;
    step();

    // R1 R9: all slots driven, 8-bit words
    runFrame("R1 R9", 2'b00, 1'b1, 4, 0, '0, '0, '0, 32'h0000_00A5);

    // R2 R12: 40 slots, only 0, 15, 39 enabled
    en = '0; en[0] = 1'b1; en[15] = 1'b1; en[39] = 1'b1;
    runFrame("R2 R12", 2'b01, 1'b1, 40, 0, en, '0, '0, 32'h0000_003C);

    // R3 R5: all copy, drive only where mask set, 16-bit words
    mk = '0; mk[1] = 1'b1; mk[4] = 1'b1; mk[6] = 1'b1;
    runFrame("R3 R5", 2'b10, 1'b1, 8, 2, '0, mk, '0, 32'h0000_BEEF);

    // R4: symmetric mode, 12-bit words
    rx = '0; rx[0] = 1'b1; rx[2] = 1'b1; rx[3] = 1'b1; rx[5] = 1'b1;
    mk = '0; mk[2] = 1'b1; mk[3] = 1'b1; mk[4] = 1'b1;
    en = '1;
    runFrame("R4", 2'b11, 1'b1, 6, 1, en, mk, rx, 32'h0000_09C3);

    // R10: folding onto the low 32 selection bits, 64 slots
    en = '0; en[3] = 1'b1; en[40] = 1'b1;
    runFrame("R10", 2'b01, 1'b0, 64, 0, en, '0, '0, 32'h0000_0081);

    // R7: one enabled slot finds a fresh word
    en = '0; en[2] = 1'b1;
    runFrame("R7", 2'b01, 1'b1, 4, 0, en, '0, '0, 32'h0000_005A);

    // R6 R7: no slot enabled, flags untouched
    runFrame("R6 R7", 2'b01, 1'b1, 4, 0, '0, '0, '0, 32'h0000_00FF);

    // R8: longest word codes
    runFrame("R8", 2'b00, 1'b1, 2, 6, '0, '0, '0, 32'hC0FF_EE11);
    runFrame("R8", 2'b00, 1'b1, 1, 7, '0, '0, '0, 32'h8123_4567);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule